// File: doc/BRIEF.md
# Vector Packet Classifier and Router

This block sits on a 32-bit word stream with a valid/ready handshake and splits it into framed vector packets. Every packet opens with a header word, carries between one and a bounded number of payload words, and closes with a tail word that must equal a configured sync constant. The header is decoded as it arrives: a type bit separates data from command packets, a target-processor field picks one of several class queues, and a length field tells the block how many payload words follow. The whole packet, header and tail included, is steered cut-through to exactly one output port. No beat is buffered inside the block; the input is stalled whenever the chosen port is not ready.

Data packets go to the class queue given by the upper bits of the target field, where the software-set shift amount decides which bits those are. Command packets go to a separate control port. A header whose length is zero or above the configured maximum is silently discarded together with every following word up to and including the next sync word. Per-class saturating counters record good data packets and errors, and a small read port returns them.

The controller has four states. HEAD waits for a header. HEAD goes to BODY on a good header and to DROP on a bad length. BODY counts the payload down and goes to TAIL after the last payload word. TAIL takes the tail word and returns to HEAD. DROP discards words and returns to HEAD when it sees the sync word.

Top module: `rv_router`

## Requirements
- R1: Header bit 26 set marks a command packet, which goes only to the control port. When bit 26 is clear, the class is the low CLS_W bits of (header[23:16] >> cfg_shift), and the packet goes only to that class port.
- R2: A packet with a good length is forwarded as header, then header[15:0] payload words, then one tail word, all in order on one port with the data unchanged. At most one output valid is high at any time, and last is high on the tail beat only.
- R3: The err output of the port is high on the tail beat when the tail word differs from cfg_sync, and low when the tail word matches it.
- R4: A header with a length field of 0 or above MAX_LEN produces no output beat. That word and every following word up to and including the next word equal to cfg_sync are accepted and discarded. The error counter of the class computed from the header is incremented, whatever the header's type bit.
- R5: While the port selected for the current beat is not ready, in_ready is low and the beat is held. When that port is ready, in_ready is high.
- R6: Each data packet whose tail matches cfg_sync increments the packet counter of its class by one. Command packets never change any packet counter.
- R7: The error counter of a class increments once for each R4 header error and once for each data packet of that class whose tail mismatches.
- R8: Both counters saturate at all ones (2^CNT_W − 1) and hold there.
- R9: After reset the controller is in HEAD, no output valid is high, and all counters read 0 through rd_cls / rd_pkt_cnt / rd_err_cnt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_shift | input | 3 | Right shift applied to the target field before class selection |
| cfg_sync | input | 32 | Expected tail word |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | 32 | Input word |
| cls_valid | output | NC | Per-class beat valid |
| cls_ready | input | NC | Per-class sink ready |
| cls_data | output | NC*32 | Per-class beat data, class c in bits [c*32 +: 32] |
| cls_last | output | NC | Per-class tail beat marker |
| cls_err | output | NC | Per-class tail mismatch marker |
| ctl_valid | output | 1 | Control port beat valid |
| ctl_ready | input | 1 | Control port sink ready |
| ctl_data | output | 32 | Control port beat data |
| ctl_last | output | 1 | Control port tail beat marker |
| ctl_err | output | 1 | Control port tail mismatch marker |
| rd_cls | input | CLS_W | Class whose counters are read |
| rd_pkt_cnt | output | CNT_W | Good data packet count of rd_cls |
| rd_err_cnt | output | CNT_W | Error count of rd_cls |

## Verification
The bench builds the router with CLS_W = 2, MAX_LEN = 8 and CNT_W = 3. The small maximum length makes both the full-length packet and the one-over-limit header cheap to send. The 3-bit counters let eight packets push a class to its saturation value of 7 in a few hundred cycles. Four classes are enough to show that different shift amounts pick different target bits.

// File: rtl/rv_router_pkg.sv
package rv_router_pkg;

    typedef enum logic [1:0] {
        ST_HEAD = 2'd0,
        ST_BODY = 2'd1,
        ST_TAIL = 2'd2,
        ST_DROP = 2'd3
    } rv_state_e;

    localparam int WORD_W       = 32;
    localparam int HDR_TYPE_BIT = 26;
    localparam int TGT_LSB      = 16;
    localparam int TGT_W        = 8;
    localparam int LENF_W       = 16;
    localparam int SHIFT_W      = 3;

endpackage

// File: rtl/rv_hdr_decode.sv
module rv_hdr_decode
    import rv_router_pkg::*;
#(
    parameter int CLS_W   = 2,
    parameter int MAX_LEN = 1024,
    parameter int LEN_W   = 11
) (
    input  logic                type_bit,
    input  logic [TGT_W-1:0]    target,
    input  logic [LENF_W-1:0]   len_field,
    input  logic [SHIFT_W-1:0]  shift,
    output logic                is_cmd,
    output logic [CLS_W-1:0]    cls,
    output logic [LEN_W-1:0]    len,
    output logic                len_bad
);

    always_comb begin
        is_cmd  = type_bit;
        cls     = CLS_W'(target >> shift);
        len     = len_field[LEN_W-1:0];
        len_bad = (len_field == '0) || (len_field > LENF_W'(MAX_LEN));
    end

endmodule

// File: rtl/rv_pkt_fsm.sv
module rv_pkt_fsm
    import rv_router_pkg::*;
#(
    parameter int CLS_W = 2,
    parameter int LEN_W = 11,
    localparam int NC   = 1 << CLS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              sync_hit,
    input  logic              hdr_cmd,
    input  logic [CLS_W-1:0]  hdr_cls,
    input  logic [LEN_W-1:0]  hdr_len,
    input  logic              hdr_bad,
    input  logic [NC-1:0]     cls_ready,
    input  logic              ctl_ready,
    output logic              in_ready,
    output logic [NC-1:0]     fwd_cls_valid,
    output logic              fwd_ctl_valid,
    output logic              tail_beat,
    output logic              ev_ok,
    output logic              ev_err,
    output logic [CLS_W-1:0]  ev_cls,
    output rv_state_e         state_o
);

    rv_state_e        state_q, state_d;
    logic             cmd_q, cmd_d;
    logic [CLS_W-1:0] cls_q, cls_d;
    logic [LEN_W-1:0] rem_q, rem_d;

    logic             cur_cmd;
    logic [CLS_W-1:0] cur_cls;
    logic             dest_rdy;
    logic             fwd;
    logic             accept;

    // Destination of the current beat: live header in HEAD, latched otherwise
    always_comb begin
        cur_cmd  = (state_q == ST_HEAD) ? hdr_cmd : cmd_q;
        cur_cls  = (state_q == ST_HEAD) ? hdr_cls : cls_q;
        dest_rdy = cur_cmd ? ctl_ready : cls_ready[cur_cls];
    end

    // Output process
    always_comb begin
        in_ready  = 1'b0;
        fwd       = 1'b0;
        tail_beat = 1'b0;
        unique case (state_q)
            ST_HEAD: begin
                if (hdr_bad) begin
                    in_ready = 1'b1;
                end else begin
                    in_ready = dest_rdy;
                    fwd      = in_valid;
                end
            end
            ST_BODY: begin
                in_ready = dest_rdy;
                fwd      = in_valid;
            end
            ST_TAIL: begin
                in_ready  = dest_rdy;
                fwd       = in_valid;
                tail_beat = 1'b1;
            end
            ST_DROP: begin
                in_ready = 1'b1;
            end
        endcase
    end

    assign accept        = in_valid & in_ready;
    assign fwd_ctl_valid = fwd & cur_cmd;

    generate
        for (genvar i = 0; i < NC; i++) begin : g_sel
            assign fwd_cls_valid[i] = fwd & ~cur_cmd & (cur_cls == CLS_W'(i));
        end
    endgenerate

    assign ev_cls = cur_cls;
    assign ev_ok  = accept & (state_q == ST_TAIL) & ~cmd_q & sync_hit;
    assign ev_err = accept & (((state_q == ST_HEAD) & hdr_bad) |
                              ((state_q == ST_TAIL) & ~cmd_q & ~sync_hit));

    // Transitions
    always_comb begin
        state_d = state_q;
        cmd_d   = cmd_q;
        cls_d   = cls_q;
        rem_d   = rem_q;
        unique case (state_q)
            ST_HEAD: begin
                if (accept) begin
                    cmd_d = hdr_cmd;
                    cls_d = hdr_cls;
                    rem_d = hdr_len;
                    state_d = hdr_bad ? ST_DROP : ST_BODY;
                end
            end
            ST_BODY: begin
                if (accept) begin
                    rem_d = rem_q - 1'b1;
                    if (rem_q == LEN_W'(1)) begin
                        state_d = ST_TAIL;
                    end
                end
            end
            ST_TAIL: begin
                if (accept) begin
                    state_d = ST_HEAD;
                end
            end
            ST_DROP: begin
                if (accept && sync_hit) begin
                    state_d = ST_HEAD;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HEAD;
            cmd_q   <= 1'b0;
            cls_q   <= '0;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            cmd_q   <= cmd_d;
            cls_q   <= cls_d;
            rem_q   <= rem_d;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/rv_class_counters.sv
module rv_class_counters #(
    parameter int CLS_W = 2,
    parameter int CNT_W = 32,
    localparam int NC   = 1 << CLS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_ok,
    input  logic              ev_err,
    input  logic [CLS_W-1:0]  ev_cls,
    input  logic [CLS_W-1:0]  rd_cls,
    output logic [CNT_W-1:0]  rd_pkt,
    output logic [CNT_W-1:0]  rd_err
);

    logic [CNT_W-1:0] pkt_q [NC];
    logic [CNT_W-1:0] err_q [NC];

    generate
        for (genvar c = 0; c < NC; c++) begin : g_cnt
            logic hit;
            assign hit = (ev_cls == CLS_W'(c));

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pkt_q[c] <= '0;
                    err_q[c] <= '0;
                end else begin
                    if (hit && ev_ok && (pkt_q[c] != '1)) begin
                        pkt_q[c] <= pkt_q[c] + 1'b1;
                    end
                    if (hit && ev_err && (err_q[c] != '1)) begin
                        err_q[c] <= err_q[c] + 1'b1;
                    end
                end
            end
        end
    endgenerate

    assign rd_pkt = pkt_q[rd_cls];
    assign rd_err = err_q[rd_cls];

endmodule

// File: rtl/rv_router.sv
module rv_router
    import rv_router_pkg::*;
#(
    parameter int CLS_W   = 2,
    parameter int MAX_LEN = 1024,
    parameter int CNT_W   = 32,
    localparam int NC     = 1 << CLS_W,
    localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SHIFT_W-1:0]   cfg_shift,
    input  logic [WORD_W-1:0]    cfg_sync,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [WORD_W-1:0]    in_data,
    output logic [NC-1:0]        cls_valid,
    input  logic [NC-1:0]        cls_ready,
    output logic [NC*WORD_W-1:0] cls_data,
    output logic [NC-1:0]        cls_last,
    output logic [NC-1:0]        cls_err,
    output logic                 ctl_valid,
    input  logic                 ctl_ready,
    output logic [WORD_W-1:0]    ctl_data,
    output logic                 ctl_last,
    output logic                 ctl_err,
    input  logic [CLS_W-1:0]     rd_cls,
    output logic [CNT_W-1:0]     rd_pkt_cnt,
    output logic [CNT_W-1:0]     rd_err_cnt
);

    logic             hdr_cmd;
    logic [CLS_W-1:0] hdr_cls;
    logic [LEN_W-1:0] hdr_len;
    logic             hdr_bad;
    logic             sync_hit;
    logic             tail_beat;
    logic             ev_ok;
    logic             ev_err;
    logic [CLS_W-1:0] ev_cls;
    rv_state_e        fsm_state;

    assign sync_hit = (in_data == cfg_sync);

    rv_hdr_decode #(
        .CLS_W   (CLS_W),
        .MAX_LEN (MAX_LEN),
        .LEN_W   (LEN_W)
    ) u_dec (
        .type_bit  (in_data[HDR_TYPE_BIT]),
        .target    (in_data[TGT_LSB +: TGT_W]),
        .len_field (in_data[LENF_W-1:0]),
        .shift     (cfg_shift),
        .is_cmd    (hdr_cmd),
        .cls       (hdr_cls),
        .len       (hdr_len),
        .len_bad   (hdr_bad)
    );

    rv_pkt_fsm #(
        .CLS_W (CLS_W),
        .LEN_W (LEN_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .sync_hit      (sync_hit),
        .hdr_cmd       (hdr_cmd),
        .hdr_cls       (hdr_cls),
        .hdr_len       (hdr_len),
        .hdr_bad       (hdr_bad),
        .cls_ready     (cls_ready),
        .ctl_ready     (ctl_ready),
        .in_ready      (in_ready),
        .fwd_cls_valid (cls_valid),
        .fwd_ctl_valid (ctl_valid),
        .tail_beat     (tail_beat),
        .ev_ok         (ev_ok),
        .ev_err        (ev_err),
        .ev_cls        (ev_cls),
        .state_o       (fsm_state)
    );

    rv_class_counters #(
        .CLS_W (CLS_W),
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_ok  (ev_ok),
        .ev_err (ev_err),
        .ev_cls (ev_cls),
        .rd_cls (rd_cls),
        .rd_pkt (rd_pkt_cnt),
        .rd_err (rd_err_cnt)
    );

    generate
        for (genvar i = 0; i < NC; i++) begin : g_port
            assign cls_data[i*WORD_W +: WORD_W] = in_data;
            assign cls_last[i] = cls_valid[i] & tail_beat;
            assign cls_err[i]  = cls_valid[i] & tail_beat & ~sync_hit;
        end
    endgenerate

    assign ctl_data = in_data;
    assign ctl_last = ctl_valid & tail_beat;
    assign ctl_err  = ctl_valid & tail_beat & ~sync_hit;

endmodule

// File: rtl/rv_router_checker.sv
module rv_router_checker
    import rv_router_pkg::*;
#(
    parameter int CLS_W = 2,
    parameter int CNT_W = 32,
    localparam int NC   = 1 << CLS_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [NC-1:0]    cls_valid,
    input logic [NC-1:0]    cls_ready,
    input logic             ctl_valid,
    input logic             ctl_ready,
    input logic [CLS_W-1:0] rd_cls,
    input logic [CNT_W-1:0] rd_pkt_cnt,
    input rv_state_e        fsm_state
);

    // R2: one destination per beat
    a_r2_one_dest: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctl_valid, cls_valid}));

    // R2: no output beat without an input word behind it
    a_r2_valid_from_input: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid || (|cls_valid)) |-> in_valid);

    // R5: a stalled destination stalls the input
    a_r5_stall: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(cls_valid & ~cls_ready)) || (ctl_valid && !ctl_ready)) |-> !in_ready);

    // R5: a ready destination takes the beat
    a_r5_pass: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(cls_valid & cls_ready)) || (ctl_valid && ctl_ready)) |-> in_ready);

    // R4: nothing leaves the block while discarding
    a_r4_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_DROP) |-> !(ctl_valid || (|cls_valid)));

    // R6: packet count never decreases for a fixed read index
    a_r6_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(rd_cls) |-> (rd_pkt_cnt >= $past(rd_pkt_cnt)));

    // R8: saturated count holds
    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(rd_cls) && ($past(rd_pkt_cnt) == '1)) |-> (rd_pkt_cnt == '1));

endmodule

bind rv_router rv_router_checker #(
    .CLS_W (CLS_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .cls_valid  (cls_valid),
    .cls_ready  (cls_ready),
    .ctl_valid  (ctl_valid),
    .ctl_ready  (ctl_ready),
    .rd_cls     (rd_cls),
    .rd_pkt_cnt (rd_pkt_cnt),
    .fsm_state  (fsm_state)
);

// File: tb/rv_router_bench.sv
module rv_router_bench;

    localparam int CLS_W   = 2;
    localparam int NC      = 1 << CLS_W;
    localparam int MAX_LEN = 8;
    localparam int CNT_W   = 3;
    localparam int SAT     = (1 << CNT_W) - 1;
    localparam logic [31:0] SYNC = 32'hC0DE_5A5A;

    // entry: {pad3, cmd, good_tail, shift[2:0], target[7:0], len[15:0]}
    localparam int NVEC = 10;
    localparam logic [31:0] VEC [NVEC] = '{
        {3'b0, 1'b0, 1'b1, 3'd0, 8'h01, 16'd3},
        {3'b0, 1'b0, 1'b1, 3'd6, 8'hC0, 16'd1},
        {3'b0, 1'b1, 1'b1, 3'd0, 8'h02, 16'd2},
        {3'b0, 1'b0, 1'b0, 3'd3, 8'h10, 16'd8},
        {3'b0, 1'b0, 1'b1, 3'd4, 8'h20, 16'd8},
        {3'b0, 1'b0, 1'b1, 3'd0, 8'h00, 16'd0},
        {3'b0, 1'b0, 1'b1, 3'd0, 8'h07, 16'd9},
        {3'b0, 1'b1, 1'b0, 3'd0, 8'h05, 16'd4},
        {3'b0, 1'b0, 1'b1, 3'd2, 8'h04, 16'd5},
        {3'b0, 1'b0, 1'b1, 3'd7, 8'h80, 16'd2}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        cfg_shift = '0;
    logic [31:0]       cfg_sync = SYNC;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [31:0]       in_data = '0;
    logic [NC-1:0]     cls_valid;
    logic [NC-1:0]     cls_ready = '1;
    logic [NC*32-1:0]  cls_data;
    logic [NC-1:0]     cls_last;
    logic [NC-1:0]     cls_err;
    logic              ctl_valid;
    logic              ctl_ready = 1'b1;
    logic [31:0]       ctl_data;
    logic              ctl_last;
    logic              ctl_err;
    logic [CLS_W-1:0]  rd_cls = '0;
    logic [CNT_W-1:0]  rd_pkt_cnt;
    logic [CNT_W-1:0]  rd_err_cnt;

    int checks = 0;
    int fails  = 0;
    int exp_pkt [NC];
    int exp_err [NC];
    bit done = 1'b0;

    always #10 clk = ~clk;

    rv_router #(
        .CLS_W   (CLS_W),
        .MAX_LEN (MAX_LEN),
        .CNT_W   (CNT_W)
    ) u_rv_router (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_shift  (cfg_shift),
        .cfg_sync   (cfg_sync),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .cls_valid  (cls_valid),
        .cls_ready  (cls_ready),
        .cls_data   (cls_data),
        .cls_last   (cls_last),
        .cls_err    (cls_err),
        .ctl_valid  (ctl_valid),
        .ctl_ready  (ctl_ready),
        .ctl_data   (ctl_data),
        .ctl_last   (ctl_last),
        .ctl_err    (ctl_err),
        .rd_cls     (rd_cls),
        .rd_pkt_cnt (rd_pkt_cnt),
        .rd_err_cnt (rd_err_cnt)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // port: -1 none, 0..NC-1 class, NC control
    task automatic send_beat(input logic [31:0] w, input int port, input bit last,
                             input bit err, input string req);
        logic [NC:0] exp_v;
        logic [NC:0] act_v;
        logic [31:0] d;
        logic        l;
        logic        e;
        in_data  = w;
        in_valid = 1'b1;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        exp_v = (port < 0) ? '0 : ((NC+1)'(1) << port);
        act_v = {ctl_valid, cls_valid};
        if (port < 0) begin
            chk(act_v == exp_v, req, "valid on discarded word", 32'(act_v), 32'(exp_v));
        end else begin
            d = (port == NC) ? ctl_data : cls_data[port*32 +: 32];
            l = (port == NC) ? ctl_last : cls_last[port];
            e = (port == NC) ? ctl_err  : cls_err[port];
            chk((act_v == exp_v) && (l == last) && (e == err), req, "valid/last/err",
                {act_v, 1'b0, l, e}, {exp_v, 1'b0, last, err});
            chk(d == w, req, "beat data", d, w);
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic bump(inout int v);
        if (v < SAT) v++;
    endtask

    task automatic send_pkt(input bit cmd, input logic [7:0] target, input int len,
                            input logic [2:0] shift, input bit good);
        int cls;
        int port;
        logic [31:0] hdr;
        cfg_shift = shift;
        cls  = int'((target >> shift) & 8'(NC - 1));
        port = cmd ? NC : cls;
        hdr  = {1'b0, 4'h1, cmd, 2'b00, target, 16'(len)};
        if (len == 0 || len > MAX_LEN) begin
            send_beat(hdr, -1, 0, 0, "R4");
            send_beat(32'h1234_0000, -1, 0, 0, "R4");
            send_beat(32'h0000_0001, -1, 0, 0, "R4");
            send_beat(SYNC, -1, 0, 0, "R4");
            bump(exp_err[cls]);
        end else begin
            send_beat(hdr, port, 0, 0, "R1");
            for (int k = 0; k < len; k++) begin
                send_beat(32'hA500_0000 + 32'(k), port, 0, 0, "R2");
            end
            send_beat(good ? SYNC : ~SYNC, port, 1, !good, "R3");
            if (!cmd) begin
                if (good) bump(exp_pkt[cls]);
                else      bump(exp_err[cls]);
            end
        end
    endtask

    task automatic check_counters(input string rp, input string re);
        for (int c = 0; c < NC; c++) begin
            rd_cls = CLS_W'(c);
            #1;
            chk(int'(rd_pkt_cnt) == exp_pkt[c], rp, $sformatf("pkt count class %0d", c),
                32'(rd_pkt_cnt), 32'(exp_pkt[c]));
            chk(int'(rd_err_cnt) == exp_err[c], re, $sformatf("err count class %0d", c),
                32'(rd_err_cnt), 32'(exp_err[c]));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NC; c++) begin
            exp_pkt[c] = 0;
            exp_err[c] = 0;
        end
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        chk({ctl_valid, cls_valid} == '0, "R9", "no valid after reset",
            32'({ctl_valid, cls_valid}), 32'd0);
        @(posedge clk);
        #1;
        check_counters("R9", "R9");

        // Vector table: R1, R2, R3, R4
        for (int i = 0; i < NVEC; i++) begin
            send_pkt(VEC[i][28], VEC[i][23:16], int'(VEC[i][15:0]),
                     VEC[i][26:24], VEC[i][27]);
        end
        // R6 / R7: counts after mixed traffic (commands never counted)
        check_counters("R6", "R7");

        // R5: stall on class 1, then release
        cfg_shift = 3'd0;
        cls_ready[1] = 1'b0;
        in_data  = {1'b0, 4'h1, 1'b0, 2'b00, 8'h01, 16'd1};
        in_valid = 1'b1;
        for (int s = 0; s < 3; s++) begin
            @(negedge clk);
            chk(!in_ready && ({ctl_valid, cls_valid} == 5'b00010), "R5",
                "stall while class not ready",
                32'({in_ready, ctl_valid, cls_valid}), 32'b000010);
        end
        @(posedge clk);
        #1;
        cls_ready[1] = 1'b1;
        send_beat({1'b0, 4'h1, 1'b0, 2'b00, 8'h01, 16'd1}, 1, 0, 0, "R5");
        cls_ready[1] = 1'b0;
        in_data  = 32'hA500_0000;
        in_valid = 1'b1;
        @(negedge clk);
        chk(!in_ready, "R5", "payload stalled", 32'(in_ready), 32'd0);
        @(posedge clk);
        #1;
        cls_ready[1] = 1'b1;
        send_beat(32'hA500_0000, 1, 0, 0, "R5");
        send_beat(SYNC, 1, 1, 0, "R5");
        bump(exp_pkt[1]);
        check_counters("R6", "R7");

        // R8: saturate class 0 counters
        for (int n = 0; n < 8; n++) begin
            send_pkt(1'b0, 8'h00, 1, 3'd0, 1'b1);
            send_pkt(1'b0, 8'h04, 0, 3'd0, 1'b1);
        end
        check_counters("R8", "R8");
        rd_cls = '0;
        #1;
        chk(int'(rd_pkt_cnt) == SAT, "R8", "pkt count held at max", 32'(rd_pkt_cnt), 32'(SAT));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule